// File: doc/BRIEF.md
# Local Interrupt Pin Entry

This block serves one external interrupt pin of a processor-local interrupt unit. A single programmable entry holds the vector, the delivery mode, the input polarity, the trigger choice and a mask. A read-only flag marks a level request that is waiting for an end-of-interrupt. The raw pin passes through a two-flop synchronizer and a polarity inverter. The result is then watched for either a rising transition or a sustained active level. An interrupt request that carries the vector and the delivery mode is offered to a core-side acceptor on a valid/ready pair.

The effective sensitivity follows the delivery mode rather than the trigger bit alone. Fixed mode obeys the trigger bit. The external-controller mode is always level sensitive. System-management, non-maskable and init modes are always edge sensitive. An instance built with `EDGE_ONLY = 1` models the pin that forbids level operation and treats every mode as edge.

For a level request, acceptance sets the remote flag. The flag then blocks repeats until an end-of-interrupt pulse clears it. Software reaches the entry through a plain write strobe and a read bus that always shows the current register image.

Back-pressure rules on the request side:
- The payload (`req_vector`, `req_mode`) is the live register content.
- For edge requests, `req_valid` stays high until a cycle with `req_ready` high, unless the entry is masked or rewritten.
- For level requests, `req_valid` follows the active, unmasked and not-remote condition, and may fall without acceptance when the input goes inactive.
- Software should not rewrite the entry while a request is offered.

Top module: `irq_pin_entry`

## Requirements
- R1: The register image places the vector in bits 7:0, the delivery mode in bits 10:8, polarity in bit 13, the remote flag in bit 14, the trigger bit in bit 15 and the mask in bit 16. All other bits read 0. A write with `wr_en` updates the fields at the next clock edge, and the fields hold when no write occurs.
- R2: After reset the register image reads 0x0001_0000 (mask set, every other field zero), and `req_valid` is low.
- R3: The input is active when the synchronized pin XOR the polarity bit is 1 (0 selects active high, 1 selects active low). With polarity 0, the pin is seen through two flops. A level request appears on the second edge after the pin changes, and an edge request appears on the third edge.
- R4: In edge sensitivity, each inactive-to-active transition of an unmasked input produces exactly one request. That request is retired by the first cycle with `req_valid` and `req_ready` both high, and a held active input produces no further request.
- R5: Delivery-mode codes are 000 Fixed, 010 system-management, 100 non-maskable, 101 init and 111 external-controller. Fixed mode uses the trigger bit (0 edge, 1 level). Mode 111 is always level. All other codes are always edge.
- R6: An instance with `EDGE_ONLY = 1` is edge sensitive in every mode, and its remote flag never sets.
- R7: In level sensitivity, `req_valid` is high exactly while the input is active, the mask is clear and the remote flag is clear.
- R8: Acceptance of a level request sets the remote flag, which suppresses further requests. An `eoi` pulse clears the flag, and if the input is still active the request reappears on the next cycle. When acceptance and `eoi` coincide, the flag sets.
- R9: With the mask at 1, `req_valid` is low. An edge arriving while masked is dropped, and setting the mask discards a pending edge request.
- R10: An offered edge request holds `req_valid` high with a stable vector and mode while `req_ready` is low and the entry is not rewritten.
- R11: Writes never change the remote flag. Only acceptance and `eoi` move it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Raw, unsynchronized interrupt pin |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | DATA_W | Register write value |
| rd_data | output | DATA_W | Current register image |
| req_valid | output | 1 | Interrupt request offered |
| req_ready | input | 1 | Acceptor takes the request this cycle |
| req_vector | output | 8 | Vector of the offered request |
| req_mode | output | 3 | Delivery mode of the offered request |
| eoi | input | 1 | End-of-interrupt pulse, clears the remote flag |

## Verification
The bench targets the places where effective sensitivity departs from the trigger bit. A non-maskable entry with the level bit set must fire only once. An external-controller entry with the level bit clear must fire again after end-of-interrupt. A design that trusted the trigger bit would repeat the first request or lose the second.

Masked edges are checked by pulsing the pin, unmasking and then expecting silence. A design that latched edges during the mask would raise a stale interrupt.

The remote flag is driven through write attempts, acceptance and end-of-interrupt. A writable flag or one missing the re-arm would show up as a stuck or a flooding level request. The edge-only instance runs beside the normal one under identical stimulus, so any level behaviour leaking into it is visible.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  localparam int VEC_W    = 8;
  localparam int MODE_W   = 3;
  localparam int VEC_LSB  = 0;
  localparam int MODE_LSB = 8;
  localparam int POL_BIT  = 13;
  localparam int RIRR_BIT = 14;
  localparam int TRIG_BIT = 15;
  localparam int MASK_BIT = 16;
  localparam int IMG_MSB  = MASK_BIT;

  typedef enum logic [MODE_W-1:0] {
    DM_FIXED  = 3'b000,
    DM_SMI    = 3'b010,
    DM_NMI    = 3'b100,
    DM_INIT   = 3'b101,
    DM_EXTCTL = 3'b111
  } dmode_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vector;
    logic [MODE_W-1:0] mode;
    logic              polarity;
    logic              trigger;
    logic              mask;
  } entry_cfg_t;

  // Effective sensitivity: 1 = level, 0 = edge.
  function automatic logic level_sensitive(input logic [MODE_W-1:0] mode,
                                           input logic trigger,
                                           input bit edge_only);
    if (edge_only) return 1'b0;
    case (mode)
      DM_FIXED:  return trigger;
      DM_EXTCTL: return 1'b1;
      default:   return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/irq_entry_regs.sv
module irq_entry_regs
  import irq_entry_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              remote,
  output entry_cfg_t        cfg,
  output logic [DATA_W-1:0] rd_data
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.vector   <= '0;
      cfg.mode     <= DM_FIXED;
      cfg.polarity <= 1'b0;
      cfg.trigger  <= 1'b0;
      cfg.mask     <= 1'b1;
    end else if (wr_en) begin
      cfg.vector   <= wr_data[VEC_LSB +: VEC_W];
      cfg.mode     <= wr_data[MODE_LSB +: MODE_W];
      cfg.polarity <= wr_data[POL_BIT];
      cfg.trigger  <= wr_data[TRIG_BIT];
      cfg.mask     <= wr_data[MASK_BIT];
    end
  end

  // Bits outside the fields, including the read-only flag, are discarded.
  logic unused_wr_bits;
  assign unused_wr_bits = ^{wr_data[DATA_W-1:IMG_MSB+1], wr_data[RIRR_BIT],
                            wr_data[POL_BIT-1:MODE_LSB+MODE_W]};

  always_comb begin
    rd_data                      = '0;
    rd_data[VEC_LSB +: VEC_W]    = cfg.vector;
    rd_data[MODE_LSB +: MODE_W]  = cfg.mode;
    rd_data[POL_BIT]             = cfg.polarity;
    rd_data[RIRR_BIT]            = remote;
    rd_data[TRIG_BIT]            = cfg.trigger;
    rd_data[MASK_BIT]            = cfg.mask;
  end

  assert_cfg_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cfg));

endmodule

// File: rtl/irq_pin_detect.sv
module irq_pin_detect #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_raw,
  input  logic polarity,
  output logic active,
  output logic rise
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= pin_raw;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_raw};
      end
    end
  endgenerate

  assign active = sync_q[SYNC_STAGES-1] ^ polarity;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= active;
  end

  assign rise = active & ~prev_q;

  assert_rise_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/irq_req_ctrl.sv
module irq_req_ctrl
  import irq_entry_pkg::*;
#(
  parameter bit EDGE_ONLY = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  entry_cfg_t cfg,
  input  logic       cfg_wr,
  input  logic       active,
  input  logic       rise,
  input  logic       req_ready,
  input  logic       eoi,
  output logic       req_valid,
  output logic       remote
);

  logic level_mode;
  logic pending_q;
  logic accept;

  assign level_mode = level_sensitive(cfg.mode, cfg.trigger, EDGE_ONLY);
  assign req_valid  = ~cfg.mask & (level_mode ? (active & ~remote) : pending_q);
  assign accept     = req_valid & req_ready;

  // Edge latch: dropped while masked or in level sensitivity.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       pending_q <= 1'b0;
    else if (level_mode || cfg.mask)  pending_q <= 1'b0;
    else if (rise)                    pending_q <= 1'b1;
    else if (accept)                  pending_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     remote <= 1'b0;
    else if (accept && level_mode)  remote <= 1'b1;
    else if (eoi)                   remote <= 1'b0;
  end

  assert_mask_blocks_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.mask |-> !req_valid);

  assert_remote_gates_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (level_mode && remote) |-> !req_valid);

  assert_remote_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && level_mode) |=> remote);

  assert_edge_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready && !level_mode && !cfg_wr) |=> req_valid);

  assert_remote_ro_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept && !eoi) |=> $stable(remote));

  generate
    if (EDGE_ONLY) begin : g_edge_chk
      assert_no_remote_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !remote);
    end
  endgenerate

endmodule

// File: rtl/irq_pin_entry.sv
module irq_pin_entry
  import irq_entry_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2,
  parameter bit EDGE_ONLY   = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_in,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VEC_W-1:0]  req_vector,
  output logic [MODE_W-1:0] req_mode,
  input  logic              eoi
);

  entry_cfg_t cfg;
  logic       remote;
  logic       active;
  logic       rise;

  irq_entry_regs #(.DATA_W(DATA_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .remote  (remote),
    .cfg     (cfg),
    .rd_data (rd_data)
  );

  irq_pin_detect #(.SYNC_STAGES(SYNC_STAGES)) u_detect (
    .clk      (clk),
    .rst_n    (rst_n),
    .pin_raw  (pin_in),
    .polarity (cfg.polarity),
    .active   (active),
    .rise     (rise)
  );

  irq_req_ctrl #(.EDGE_ONLY(EDGE_ONLY)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg       (cfg),
    .cfg_wr    (wr_en),
    .active    (active),
    .rise      (rise),
    .req_ready (req_ready),
    .eoi       (eoi),
    .req_valid (req_valid),
    .remote    (remote)
  );

  assign req_vector = cfg.vector;
  assign req_mode   = cfg.mode;

endmodule

// File: tb/irq_pin_entry_test.sv
module irq_pin_entry_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_in = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        req_ready = 1'b0;
  logic        eoi = 1'b0;

  logic [31:0] rd_a, rd_b;
  logic        v_a, v_b;
  logic [7:0]  vec_a, vec_b;
  logic [2:0]  mode_a, mode_b;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  bit model_on = 1'b0;

  always #2 clk = ~clk;

  irq_pin_entry #(.EDGE_ONLY(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_a), .req_valid(v_a), .req_ready(req_ready), .req_vector(vec_a),
    .req_mode(mode_a), .eoi(eoi));

  irq_pin_entry #(.EDGE_ONLY(1'b1)) uut_edge (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_b), .req_valid(v_b), .req_ready(req_ready), .req_vector(vec_b),
    .req_mode(mode_b), .eoi(eoi));

  // ---------------- reference model from the requirements ----------------
  bit [7:0] m_vec;
  bit [2:0] m_mode;
  bit       m_pol, m_trig, m_mask;
  bit [1:0] m_s1, m_s2, m_prev, m_pend, m_rem;

  function automatic bit f_level(input bit [2:0] mode, input bit trig, input bit edge_only);
    if (edge_only) return 1'b0;                 // R6
    if (mode == 3'b000) return trig;            // R5 Fixed
    if (mode == 3'b111) return 1'b1;            // R5 external controller
    return 1'b0;
  endfunction

  function automatic bit f_valid(input int i);
    bit act;
    act = m_s2[i] ^ m_pol;
    if (m_mask) return 1'b0;
    if (f_level(m_mode, m_trig, i == 1)) return act & ~m_rem[i];
    return m_pend[i];
  endfunction

  function automatic bit [31:0] f_image(input int i);
    return {15'd0, m_mask, m_trig, m_rem[i], m_pol, 2'b00, m_mode, m_vec};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_vec <= '0; m_mode <= '0; m_pol <= 1'b0; m_trig <= 1'b0; m_mask <= 1'b1;
      m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_pend <= '0; m_rem <= '0;
    end else begin
      bit [1:0] n_pend, n_rem, n_prev;
      for (int i = 0; i < 2; i++) begin
        bit lvl, act, acc;
        lvl = f_level(m_mode, m_trig, i == 1);
        act = m_s2[i] ^ m_pol;
        acc = f_valid(i) & req_ready;
        n_pend[i] = (lvl | m_mask) ? 1'b0 : (act & ~m_prev[i]) ? 1'b1 : acc ? 1'b0 : m_pend[i];
        n_rem[i]  = (acc & lvl) ? 1'b1 : eoi ? 1'b0 : m_rem[i];
        n_prev[i] = act;
      end
      m_pend <= n_pend; m_rem <= n_rem; m_prev <= n_prev;
      m_s2 <= m_s1; m_s1 <= {2{pin_in}};
      if (wr_en) begin
        m_vec <= wr_data[7:0]; m_mode <= wr_data[10:8]; m_pol <= wr_data[13];
        m_trig <= wr_data[15]; m_mask <= wr_data[16];
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string valid_tag(input int i);
    if (i == 1) return "R6";
    if (m_mask) return "R9";
    if (f_level(m_mode, m_trig, 1'b0)) return "R7";
    return "R4";
  endfunction

  // Cycle-by-cycle comparison, sampled at the falling edge.
  always @(negedge clk) begin
    if (rst_n && model_on) begin
      chk(rd_a == f_image(0), "R1", rd_a, f_image(0));
      chk(rd_b == f_image(1), "R6", rd_b, f_image(1));
      chk(v_a == f_valid(0), valid_tag(0), {31'd0, v_a}, {31'd0, f_valid(0)});
      chk(v_b == f_valid(1), valid_tag(1), {31'd0, v_b}, {31'd0, f_valid(1)});
      chk({mode_a, vec_a} == {m_mode, m_vec}, "R10", {21'd0, mode_a, vec_a}, {21'd0, m_mode, m_vec});
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse_ready();
    req_ready = 1'b1; @(negedge clk); req_ready = 1'b0;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    void'($urandom(32'd20240611));
    step(3);
    rst_n = 1'b1;
    step(1);
    model_on = 1'b1;
    chk(rd_a == 32'h0001_0000, "R2", rd_a, 32'h0001_0000);
    chk(v_a == 1'b0 && v_b == 1'b0, "R2", {31'd0, v_a | v_b}, 32'd0);

    wr(32'hFFFF_FFFF);                            // R11 remote bit not writable
    chk(rd_a == 32'h0001_A7FF, "R11", rd_a, 32'h0001_A7FF);

    wr(32'h0000_0041);                            // Fixed, edge, unmasked
    chk(rd_a == 32'h0000_0041, "R1", rd_a, 32'h0000_0041);
    pin_in = 1'b1;
    step(2);
    chk(v_a == 1'b0, "R3", {31'd0, v_a}, 32'd0);  // after two edges: not yet
    step(1);
    chk(v_a == 1'b1 && vec_a == 8'h41, "R3", {23'd0, v_a, vec_a}, {23'd0, 1'b1, 8'h41});
    step(4);
    chk(v_a == 1'b1 && mode_a == 3'b000, "R10", {28'd0, v_a, mode_a}, {28'd0, 1'b1, 3'b000});
    pulse_ready();
    chk(v_a == 1'b0, "R4", {31'd0, v_a}, 32'd0);
    step(3);
    chk(v_a == 1'b0, "R4", {31'd0, v_a}, 32'd0);  // held level gives no repeat
    pin_in = 1'b0;
    step(3);

    wr(32'h0000_2041);                            // polarity active low, pin low
    step(2);
    chk(v_a == 1'b1, "R3", {31'd0, v_a}, 32'd1);
    pulse_ready();
    wr(32'h0000_8441);                            // NMI with trigger bit set
    step(3);
    pin_in = 1'b1;
    step(3);
    chk(v_a == 1'b1, "R5", {31'd0, v_a}, 32'd1);
    pulse_ready();
    step(4);
    chk(v_a == 1'b0 && rd_a[14] == 1'b0, "R5", {30'd0, v_a, rd_a[14]}, 32'd0);

    pin_in = 1'b0;
    step(3);
    wr(32'h0000_0741);                            // external controller, trigger clear
    pin_in = 1'b1;
    step(3);
    chk(v_a == 1'b1, "R5", {31'd0, v_a}, 32'd1);
    chk(v_b == 1'b1, "R6", {31'd0, v_b}, 32'd1);
    pulse_ready();
    chk(v_a == 1'b0 && rd_a[14] == 1'b1, "R8", {30'd0, v_a, rd_a[14]}, 32'd1);
    chk(rd_b[14] == 1'b0, "R6", {31'd0, rd_b[14]}, 32'd0);
    step(3);
    chk(v_a == 1'b0, "R8", {31'd0, v_a}, 32'd0);
    wr(32'h0000_0741);
    chk(rd_a[14] == 1'b1, "R11", {31'd0, rd_a[14]}, 32'd1);
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    chk(v_a == 1'b1 && rd_a[14] == 1'b0, "R8", {30'd0, v_a, rd_a[14]}, 32'd2);
    chk(v_b == 1'b0, "R6", {31'd0, v_b}, 32'd0);
    req_ready = 1'b1; eoi = 1'b1; @(negedge clk); req_ready = 1'b0; eoi = 1'b0;
    chk(rd_a[14] == 1'b1, "R8", {31'd0, rd_a[14]}, 32'd1);
    eoi = 1'b1; @(negedge clk); eoi = 1'b0;
    pin_in = 1'b0;
    step(3);

    wr(32'h0001_0041);                            // masked edge entry
    pin_in = 1'b1; step(4); pin_in = 1'b0; step(3);
    wr(32'h0000_0041);
    step(4);
    chk(v_a == 1'b0, "R9", {31'd0, v_a}, 32'd0);
    pin_in = 1'b1; step(3);
    wr(32'h0001_0041);                            // mask discards pending edge
    wr(32'h0000_0041);
    chk(v_a == 1'b0, "R9", {31'd0, v_a}, 32'd0);

    wr(32'h0001_8041);                            // Fixed level, masked, pin high
    step(3);
    chk(v_a == 1'b0, "R9", {31'd0, v_a}, 32'd0);
    wr(32'h0000_8041);
    chk(v_a == 1'b1, "R7", {31'd0, v_a}, 32'd1);
    pin_in = 1'b0;
    step(2);
    chk(v_a == 1'b0, "R7", {31'd0, v_a}, 32'd0);

    // Constrained random phase, checked every cycle against the model.
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 6 == 0) pin_in = ~pin_in;
      req_ready = ($urandom % 3) != 0;
      eoi = ($urandom % 8) == 0;
      if ($urandom % 30 == 0) begin
        wr_en = 1'b1;
        wr_data = $urandom;
        wr_data[16] = ($urandom % 4) == 0;
      end else begin
        wr_en = 1'b0;
      end
      @(negedge clk);
    end
    wr_en = 1'b0; req_ready = 1'b0; eoi = 1'b0;
    step(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule